// File: doc/BRIEF.md
# Floating-point coprocessor control register unit

This block holds the two control registers of a floating-point coprocessor. It serves the integer pipeline's move-from-control and move-to-control requests. One register is a read-only identity word, reached at index 0. The other is a control/status word, reached at index 31. The control/status word carries five fields:

- rounding mode
- sticky exception flags
- per-exception enables
- cause bits for the latest operation
- a compare condition bit and a denormal-flush bit

The block drives the rounding mode and the flush bit out to the arithmetic datapath. It drives the condition bit out to branch logic.

Each request carries a 5-bit sub-opcode, a 5-bit control register index and a 64-bit general register value. The block first checks that the coprocessor may be used. It then decodes the request and returns one registered result in the cycle after the request. The result is one of the following:

- read data
- a reserved-instruction pulse
- a coprocessor-unusable pulse carrying the unit number
- a floating-point exception pulse

Two side inputs let the arithmetic units post a compare result and a set of cause bits.

Top module: `fcsr_unit`

## Requirements
- R1: After reset the control/status word is zero, so the rounding mode, flush bit and condition output are 0, and all exception and read-valid outputs are low.
- R2: A move-from-control (sub-opcode 0b00010) at index 0 returns the identity word sign-extended to 64 bits, one cycle later with readValid high. Bits 7:0 of the identity word hold the revision parameter and bits 15:8 hold the implementation number (default 0x0B), so the default value is 0x0B00.
- R3: A move-from-control at index 31 returns the control/status word sign-extended from bit 31 to 64 bits, one cycle later with readValid high.
- R4: A move-to-control (sub-opcode 0b00110) at index 31 stores bits 31:0 of the source. From the next cycle roundMode shows bits 1:0, flushDenorm shows bit 24 and condition shows bit 23. Rounding encodings: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf.
- R5: A move-to-control at index 31 raises excFpe one cycle later when the written cause field (bits 17:12) ANDed with the enable field (bits 11:7) is nonzero. The unimplemented cause bit 17 always counts as enabled. The word is still written.
- R6: A move-to-control at index 0 has no effect. No exception is raised and the identity word does not change.
- R7: A move-from-control or move-to-control at any index other than 0 or 31 raises excReserved one cycle later. It returns no read data and writes nothing.
- R8: A request with any other sub-opcode raises excReserved and changes nothing.
- R9: When the unit is not usable, a request raises excUnusable with excUnit equal to the unit number, and the registers are not touched. The unit is usable when cuEnable is set, or, for unit 0 only, when kernelMode is set.
- R10: A compare result (cmpValid) sets or clears bit 23 and the condition output at the next clock edge. A move-to-control at index 31 in the same cycle takes priority.
- R11: A cause update (causeValid) replaces bits 17:12 with causeBits. It ORs into the flag field (bits 6:2, low bit = inexact, then underflow, overflow, divide-by-zero, invalid) each of causeBits[4:0] whose enable bit is clear. Flags are never cleared except by a move-to-control write.
- R12: Exception outputs are one-cycle pulses, and at most one of excReserved, excUnusable and excFpe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Control move request valid |
| reqSubOp | input | 5 | Sub-opcode (0b00010 read, 0b00110 write) |
| reqIndex | input | 5 | Control register index |
| reqData | input | 64 | General register source value |
| cuEnable | input | 1 | Usable-enable bit for this coprocessor |
| kernelMode | input | 1 | Processor in kernel mode |
| cmpValid | input | 1 | Compare result strobe |
| cmpResult | input | 1 | Compare outcome |
| causeValid | input | 1 | Cause update strobe |
| causeBits | input | 6 | New cause field |
| readValid | output | 1 | Read data valid pulse |
| readData | output | 64 | Sign-extended register value |
| excReserved | output | 1 | Reserved-instruction pulse |
| excUnusable | output | 1 | Coprocessor-unusable pulse |
| excUnit | output | 2 | Unit number for the unusable pulse |
| excFpe | output | 1 | Floating-point exception pulse |
| roundMode | output | 2 | Current rounding mode |
| flushDenorm | output | 1 | Denormal flush enable |
| condition | output | 1 | Compare condition to branch logic |

## Verification
The assertions assume that every input holds a defined value from the first clock edge. They also assume that a compare result or cause update arriving together with an index-31 write is meant to lose to that write. The stimulus initialises all inputs before reset is released. Each request is held for exactly one cycle, placed at the falling edge, and is always followed by a known expected result. The side strobes are combined with a write only in the one case that tests the priority.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
  localparam logic [4:0] SUB_MFC = 5'b00010;
  localparam logic [4:0] SUB_MTC = 5'b00110;
  localparam logic [4:0] IDX_ID  = 5'd0;
  localparam logic [4:0] IDX_CS  = 5'd31;
  localparam int CS_COND  = 23;
  localparam int CS_FS    = 24;
  localparam int CAUSE_LO = 12;
  localparam int ENA_LO   = 7;
  localparam int FLAG_LO  = 2;

  typedef struct packed {
    logic wrCs;
    logic rdId;
    logic rdCs;
    logic cmpUpd;
    logic causeUpd;
  } strobe_t;
endpackage

// File: rtl/fcsr_ctrl.sv
module fcsr_ctrl
  import fcsr_pkg::*;
#(
  parameter int UNIT_NUM = 1,
  parameter int UNIT_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [4:0]        reqSubOp,
  input  logic [4:0]        reqIndex,
  input  logic [31:0]       reqLow,
  input  logic              cuEnable,
  input  logic              kernelMode,
  input  logic              cmpValid,
  input  logic              causeValid,
  output strobe_t           strb,
  output logic              readValid,
  output logic              excReserved,
  output logic              excUnusable,
  output logic [UNIT_W-1:0] excUnit,
  output logic              excFpe
);
  localparam bit KERNEL_OK = (UNIT_NUM == 0);

  logic usable, rsvd, unus, fpe;

  assign usable = cuEnable || (KERNEL_OK && kernelMode);

  always_comb begin
    strb          = '0;
    rsvd          = 1'b0;
    unus          = 1'b0;
    fpe           = 1'b0;
    strb.cmpUpd   = cmpValid;
    strb.causeUpd = causeValid;
    if (reqValid) begin
      if (!usable) begin
        unus = 1'b1;
      end else begin
        case (reqSubOp)
          SUB_MFC: begin
            if (reqIndex == IDX_ID)      strb.rdId = 1'b1;
            else if (reqIndex == IDX_CS) strb.rdCs = 1'b1;
            else                         rsvd = 1'b1;
          end
          SUB_MTC: begin
            if (reqIndex == IDX_CS) begin
              strb.wrCs = 1'b1;
              fpe = |(reqLow[CAUSE_LO+5:CAUSE_LO] & {1'b1, reqLow[ENA_LO+4:ENA_LO]});
            end else if (reqIndex != IDX_ID) begin
              rsvd = 1'b1;
            end
          end
          default: rsvd = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readValid   <= 1'b0;
      excReserved <= 1'b0;
      excUnusable <= 1'b0;
      excUnit     <= '0;
      excFpe      <= 1'b0;
    end else begin
      readValid   <= strb.rdId | strb.rdCs;
      excReserved <= rsvd;
      excUnusable <= unus;
      excUnit     <= unus ? UNIT_W'(UNIT_NUM) : '0;
      excFpe      <= fpe;
    end
  end

  // R12
  exc_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({excReserved, excUnusable, excFpe}));

  // R9
  unusable_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    excUnusable |-> $past(reqValid));

  // R5
  fpe_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    excFpe |-> $past(reqValid && reqSubOp == SUB_MTC && reqIndex == IDX_CS));

  // R7
  reserved_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    excReserved |-> ($past(reqValid) && !readValid));
endmodule

// File: rtl/fcsr_regs.sv
module fcsr_regs
  import fcsr_pkg::*;
#(
  parameter logic [7:0] REV = 8'h00,
  parameter logic [7:0] IMP = 8'h0B
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     strb,
  input  logic [31:0] wrData,
  input  logic        cmpResult,
  input  logic [5:0]  causeBits,
  output logic [63:0] readData,
  output logic [1:0]  roundMode,
  output logic        flushDenorm,
  output logic        condition
);
  localparam logic [31:0] ID_WORD = {16'h0000, IMP, REV};

  logic [31:0] csReg, csNext;

  always_comb begin
    csNext = csReg;
    if (strb.wrCs) begin
      csNext = wrData;
    end else begin
      if (strb.cmpUpd) csNext[CS_COND] = cmpResult;
      if (strb.causeUpd) begin
        csNext[CAUSE_LO+5:CAUSE_LO] = causeBits;
        csNext[FLAG_LO+4:FLAG_LO] = csReg[FLAG_LO+4:FLAG_LO]
                                  | (causeBits[4:0] & ~csReg[ENA_LO+4:ENA_LO]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csReg    <= '0;
      readData <= '0;
    end else begin
      csReg <= csNext;
      if (strb.rdId)      readData <= {{32{ID_WORD[31]}}, ID_WORD};
      else if (strb.rdCs) readData <= {{32{csReg[31]}}, csReg};
    end
  end

  assign roundMode   = csReg[1:0];
  assign flushDenorm = csReg[CS_FS];
  assign condition   = csReg[CS_COND];

  // R10
  cmp_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmpUpd && !strb.wrCs) |=> (condition == $past(cmpResult)));

  // R11
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrCs |=> ((csReg[FLAG_LO+4:FLAG_LO] & $past(csReg[FLAG_LO+4:FLAG_LO]))
                    == $past(csReg[FLAG_LO+4:FLAG_LO])));

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrCs |=> ($stable(roundMode) && $stable(flushDenorm)));
endmodule

// File: rtl/fcsr_unit.sv
module fcsr_unit
  import fcsr_pkg::*;
#(
  parameter int         UNIT_NUM = 1,
  parameter int         UNIT_W   = 2,
  parameter logic [7:0] REV      = 8'h00,
  parameter logic [7:0] IMP      = 8'h0B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [4:0]        reqSubOp,
  input  logic [4:0]        reqIndex,
  input  logic [63:0]       reqData,
  input  logic              cuEnable,
  input  logic              kernelMode,
  input  logic              cmpValid,
  input  logic              cmpResult,
  input  logic              causeValid,
  input  logic [5:0]        causeBits,
  output logic              readValid,
  output logic [63:0]       readData,
  output logic              excReserved,
  output logic              excUnusable,
  output logic [UNIT_W-1:0] excUnit,
  output logic              excFpe,
  output logic [1:0]        roundMode,
  output logic              flushDenorm,
  output logic              condition
);
  strobe_t strb;

  fcsr_ctrl #(.UNIT_NUM(UNIT_NUM), .UNIT_W(UNIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSubOp(reqSubOp),
    .reqIndex(reqIndex), .reqLow(reqData[31:0]), .cuEnable(cuEnable),
    .kernelMode(kernelMode), .cmpValid(cmpValid), .causeValid(causeValid),
    .strb(strb), .readValid(readValid), .excReserved(excReserved),
    .excUnusable(excUnusable), .excUnit(excUnit), .excFpe(excFpe)
  );

  fcsr_regs #(.REV(REV), .IMP(IMP)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(reqData[31:0]),
    .cmpResult(cmpResult), .causeBits(causeBits), .readData(readData),
    .roundMode(roundMode), .flushDenorm(flushDenorm), .condition(condition)
  );
endmodule

// File: tb/fcsr_unit_tb.sv
`timescale 1ns/1ps
module fcsr_unit_tb;
  localparam logic [4:0] MFC = 5'b00010;
  localparam logic [4:0] MTC = 5'b00110;
  localparam logic [63:0] ID_EXP = 64'h0000_0000_0000_0B00;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, cuEnable = 1, kernelMode = 0, cmpValid = 0, cmpResult = 0, causeValid = 0;
  logic [4:0] reqSubOp = '0, reqIndex = '0;
  logic [63:0] reqData = '0;
  logic [5:0] causeBits = '0;
  logic readValid, excReserved, excUnusable, excFpe, flushDenorm, condition;
  logic [63:0] readData;
  logic [1:0] excUnit, roundMode;

  always #2 clk = ~clk;

  fcsr_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSubOp(reqSubOp),
    .reqIndex(reqIndex), .reqData(reqData), .cuEnable(cuEnable),
    .kernelMode(kernelMode), .cmpValid(cmpValid), .cmpResult(cmpResult),
    .causeValid(causeValid), .causeBits(causeBits), .readValid(readValid),
    .readData(readData), .excReserved(excReserved), .excUnusable(excUnusable),
    .excUnit(excUnit), .excFpe(excFpe), .roundMode(roundMode),
    .flushDenorm(flushDenorm), .condition(condition)
  );

  typedef struct {
    logic rv; logic [63:0] rd; logic er; logic eu; logic [1:0] un;
    logic ef; logic [1:0] rm; logic fs; logic cd; string tag;
  } exp_t;

  exp_t q[$];
  logic [31:0] model = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input exp_t e);
    logic ok;
    ok = (readValid == e.rv) && (!e.rv || readData == e.rd) && (excReserved == e.er)
      && (excUnusable == e.eu) && (excUnit == e.un) && (excFpe == e.ef)
      && (roundMode == e.rm) && (flushDenorm == e.fs) && (condition == e.cd);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual rv=%b rd=%h er=%b eu=%b un=%0d ef=%b rm=%0d fs=%b cd=%b expected rv=%b rd=%h er=%b eu=%b un=%0d ef=%b rm=%0d fs=%b cd=%b",
        e.tag, readValid, readData, excReserved, excUnusable, excUnit, excFpe, roundMode, flushDenorm, condition,
        e.rv, e.rd, e.er, e.eu, e.un, e.ef, e.rm, e.fs, e.cd);
    end
  endtask

  // monitor: pops one expected item per cycle, sampled 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) check(q.pop_front());
  end

  task automatic drive(input logic v, input logic [4:0] so, input logic [4:0] ix,
                       input logic [63:0] d, input logic cu, input logic km,
                       input logic cv, input logic cr, input logic qv,
                       input logic [5:0] qb, input string tag);
    exp_t e;
    logic wr;
    @(negedge clk);
    reqValid = v; reqSubOp = so; reqIndex = ix; reqData = d; cuEnable = cu;
    kernelMode = km; cmpValid = cv; cmpResult = cr; causeValid = qv; causeBits = qb;
    e.rv = 0; e.rd = '0; e.er = 0; e.eu = 0; e.un = 0; e.ef = 0; e.tag = tag;
    wr = 0;
    if (v) begin
      if (!cu) begin e.eu = 1; e.un = 2'd1; end
      else if (so == MFC) begin
        if (ix == 0) begin e.rv = 1; e.rd = ID_EXP; end
        else if (ix == 31) begin e.rv = 1; e.rd = {{32{model[31]}}, model}; end
        else e.er = 1;
      end else if (so == MTC) begin
        if (ix == 31) begin
          wr = 1;
          e.ef = |(d[17:12] & {1'b1, d[11:7]});
          model = d[31:0];
        end else if (ix != 0) e.er = 1;
      end else e.er = 1;
    end
    if (!wr) begin
      if (cv) model[23] = cr;
      if (qv) begin
        model[6:2] = model[6:2] | (qb[4:0] & ~model[11:7]);
        model[17:12] = qb;
      end
    end
    e.rm = model[1:0]; e.fs = model[24]; e.cd = model[23];
    q.push_back(e);
  endtask

  task automatic mfc(input logic [4:0] ix, input string tag);
    drive(1, MFC, ix, '0, 1, 0, 0, 0, 0, '0, tag);
  endtask
  task automatic mtc(input logic [4:0] ix, input logic [63:0] d, input string tag);
    drive(1, MTC, ix, d, 1, 0, 0, 0, 0, '0, tag);
  endtask
  task automatic idle(input string tag);
    drive(0, '0, '0, '0, 1, 0, 0, 0, 0, '0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    idle("R1 reset state");
    mfc(5'd31, "R1 word zero after reset");
    mfc(5'd0, "R2 identity read");
    mtc(5'd31, 64'h0000_0000_0180_0003, "R4 write mode fs cond");
    mfc(5'd31, "R3 read back");
    mtc(5'd31, 64'h1234_5678_0000_0001, "R4 upper source bits dropped");
    mtc(5'd31, 64'hFFFF_FFFF_FFFF_FFFF, "R5 all set raises fpe");
    idle("R12 fpe pulse ends");
    mfc(5'd31, "R3 sign extension");
    mtc(5'd31, 64'h0000_0000_0002_0000, "R5 unimplemented always enabled");
    mtc(5'd31, 64'h0000_0000_0000_1000, "R5 masked cause no fpe");
    mtc(5'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R6 write index 0 ignored");
    mfc(5'd0, "R6 identity unchanged");
    mfc(5'd31, "R6 status unchanged");
    mfc(5'd5, "R7 read bad index");
    mtc(5'd7, 64'h0000_0000_0000_0003, "R7 write bad index");
    mfc(5'd31, "R7 nothing written");
    drive(1, 5'b00000, 5'd31, 64'h3, 1, 0, 0, 0, 0, '0, "R8 bad subop");
    drive(1, 5'b11111, 5'd0, 64'h3, 1, 0, 0, 0, 0, '0, "R8 bad subop 2");
    mfc(5'd31, "R8 nothing written");
    drive(1, MFC, 5'd31, '0, 0, 0, 0, 0, 0, '0, "R9 unusable read");
    drive(1, MTC, 5'd31, 64'h3, 0, 1, 0, 0, 0, '0, "R9 kernel no help for unit 1");
    mfc(5'd31, "R9 not written");
    drive(0, '0, '0, '0, 1, 0, 1, 1, 0, '0, "R10 compare true");
    drive(0, '0, '0, '0, 1, 0, 1, 0, 0, '0, "R10 compare false");
    drive(1, MTC, 5'd31, 64'h0080_0000, 1, 0, 1, 0, 0, '0, "R10 write wins over compare");
    mtc(5'd31, 64'h0000_0000_0000_0200, "R11 enable overflow");
    drive(0, '0, '0, '0, 1, 0, 0, 0, 1, 6'b000101, "R11 cause update");
    mfc(5'd31, "R11 flags and cause");
    drive(0, '0, '0, '0, 1, 0, 0, 0, 1, 6'b000000, "R11 cause cleared");
    mfc(5'd31, "R11 flags sticky");
    idle("R12 quiet");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule